// File: doc/BRIEF.md
# Multichannel DMA Channel Engine

This block moves data between memory-mapped locations without involving a processor. It holds sixteen channels, each with its own live transfer context (current source and destination, element width, address-update rule for each side, and remaining element and frame counts). One shared engine performs every move. It reads one element through a read request port, writes it through a write request port, and then updates the owning channel's context.

A channel starts work when its event input is seen high on a clock edge. An element-synchronised channel moves one element per event. A frame-synchronised channel moves a whole frame per event. When several channels wait at once, a per-channel priority field decides which one the engine serves next.

Parameter sets are written into a small store through a configuration write port. The first sixteen sets belong to the channels of the same number. The remaining sets only serve as link targets. When a block ends, a channel can do one of three things: load a linked set, reload its own set, or go idle.

Top module: `dma_chan_engine`

## Requirements
- R1: After a synchronous reset, `rd_req`, `wr_req` and `irq` are low, and every channel is unarmed.
- R2: A set has five 32-bit words, selected by `cfg_word`: 0 options, 1 source address, 2 destination address, 3 counts, 4 indices. The options word holds: bits [1:0] width code, [3:2] source mode, [5:4] destination mode, [6] frame sync, [7] reload, [8] link enable, [11:9] priority, and the link set number from bit 16 upward. A write to word 0 of set c, where c is below the channel count, loads set c into channel c and arms the channel two edges later.
- R3: Width code 0, 1 and 2 moves 1, 2 and 4 bytes. Data is right-aligned on `rd_data` and `wr_data`, and `wr_size` equals the `rd_size` of the read that supplied the data.
- R4: Mode 0 keeps an address fixed, mode 1 adds the element byte count, mode 2 subtracts it, and mode 3 adds a sign-extended 16-bit index. The source index is in word 4 [15:0] and the destination index is in word 4 [31:16].
- R5: Word 3 [15:0] gives the elements per frame and word 3 [31:16] gives the frames per block. Without frame sync, one event moves exactly one element. With frame sync, one event moves all remaining elements of the current frame.
- R6: An event on an unarmed channel is dropped. Each channel keeps at most one pending event. An event seen on the same edge at which the engine consumes that channel's pending event stays pending.
- R7: Among pending channels, the one with the highest priority field is served first. On equal priority, the lowest channel number wins.
- R8: A read request holds its address and size until `rd_ack`, and a write request holds its address and data until `wr_ack`. Each accepted read is followed on the next cycle by a write. Read and write requests are never high together.
- R9: `irq[c]` pulses high for exactly one cycle, two cycles after the write handshake of the last element of channel c's block. At most one bit of `irq` is high at a time.
- R10: At block end, with reload set and link clear, the channel reloads its own set and restarts from the original addresses.
- R11: At block end, with link enable set, the channel loads the named set, whether or not reload is set.
- R12: At block end, with neither reload nor link set, the channel disarms, and later events move nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Parameter word write strobe |
| cfg_set | input | $clog2(NSETS) | Target parameter set |
| cfg_word | input | 3 | Word within the set (0..4) |
| cfg_wdata | input | 32 | Word value |
| evt | input | NCH | Per-channel trigger events |
| rd_req | output | 1 | Read request valid |
| rd_addr | output | AW | Read byte address |
| rd_size | output | 2 | Read width code |
| rd_ack | input | 1 | Read accepted, data valid |
| rd_data | input | 32 | Right-aligned read data |
| wr_req | output | 1 | Write request valid |
| wr_addr | output | AW | Write byte address |
| wr_size | output | 2 | Write width code |
| wr_data | output | 32 | Right-aligned write data |
| wr_ack | input | 1 | Write accepted |
| irq | output | NCH | Per-channel block-complete pulses |

## Verification
Two things can happen on the same edge: the arrival of a fresh event, and the consumption of that channel's pending event when the engine grants it. The bench provokes this by holding one channel's event high for three consecutive edges, starting while the engine is idle. The pending flag is set on the first edge and granted on the second, so the event seen on the second edge coincides with the grant. The check passes only if exactly two elements are written: one for the consumed event, and one for the event that arrived on the grant edge, while the third edge adds nothing because one pending event is the limit.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    AM_HOLD = 2'd0,
    AM_INC  = 2'd1,
    AM_DEC  = 2'd2,
    AM_IDX  = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_UPD  = 2'd3
  } eng_st_e;

  typedef struct packed {
    logic [31:0] idx;
    logic [31:0] cnt;
    logic [31:0] dst;
    logic [31:0] src;
    logic [31:0] opt;
  } pset_t;

  localparam int OPT_FSYNC  = 6;
  localparam int OPT_RELOAD = 7;
  localparam int OPT_LINK   = 8;
  localparam int OPT_PRIO   = 9;
  localparam int OPT_LSET   = 16;

  function automatic logic [31:0] lane_mask(input logic [31:0] d, input logic [1:0] sz);
    case (sz)
      2'd0:    lane_mask = {24'd0, d[7:0]};
      2'd1:    lane_mask = {16'd0, d[15:0]};
      default: lane_mask = d;
    endcase
  endfunction

endpackage

// File: rtl/dma_param_store.sv
module dma_param_store
  import dma_chan_pkg::*;
#(
  parameter int NSETS = 32,
  parameter int NRD   = 2,
  localparam int SETW = $clog2(NSETS)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [SETW-1:0]           wset,
  input  logic [2:0]                wword,
  input  logic [31:0]               wdata,
  input  logic [NRD-1:0][SETW-1:0]  rd_idx,
  output pset_t [NRD-1:0]           rd_set
);

  pset_t sets [NSETS];

  always_ff @(posedge clk) begin
    if (we) begin
      case (wword)
        3'd0:    sets[wset].opt <= wdata;
        3'd1:    sets[wset].src <= wdata;
        3'd2:    sets[wset].dst <= wdata;
        3'd3:    sets[wset].cnt <= wdata;
        3'd4:    sets[wset].idx <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_set[g] = sets[rd_idx[g]];
  end

endmodule

// File: rtl/dma_evt_arbiter.sv
module dma_evt_arbiter #(
  parameter int NCH = 16,
  parameter int PW  = 3,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          evt,
  input  logic [NCH-1:0]          armed,
  input  logic [NCH-1:0][PW-1:0]  prio,
  input  logic                    take,
  input  logic [CHW-1:0]          take_ch,
  output logic                    gnt_v,
  output logic [CHW-1:0]          gnt_ch
);

  logic [NCH-1:0] pend;
  logic [NCH-1:0] req;
  logic [NCH-1:0] clr;
  logic [PW-1:0]  best;

  assign req = pend & armed;

  always_comb begin
    clr = '0;
    if (take) clr[take_ch] = 1'b1;
  end

  // a fresh event outranks the clear of the one being consumed
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= ((pend & ~clr) | evt) & armed;
  end

  // scan downward so that on equal priority a lower index overrides
  always_comb begin
    gnt_v  = 1'b0;
    gnt_ch = '0;
    best   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i] && (!gnt_v || prio[i] >= best)) begin
        gnt_v  = 1'b1;
        gnt_ch = CHW'(i);
        best   = prio[i];
      end
    end
  end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_chan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [1:0]    mode,
  input  logic [1:0]    esize,
  input  logic [15:0]   idx,
  output logic [AW-1:0] nxt
);

  logic [AW-1:0] nbytes;
  logic [AW-1:0] sidx;

  assign nbytes = AW'(1) << esize;
  assign sidx   = {{(AW-16){idx[15]}}, idx};

  always_comb begin
    case (amode_e'(mode))
      AM_INC:  nxt = cur + nbytes;
      AM_DEC:  nxt = cur - nbytes;
      AM_IDX:  nxt = cur + sidx;
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int NSETS = 32,
  parameter int AW    = 32,
  parameter int PW    = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [$clog2(NSETS)-1:0] cfg_set,
  input  logic [2:0]               cfg_word,
  input  logic [31:0]              cfg_wdata,
  input  logic [NCH-1:0]           evt,
  output logic                     rd_req,
  output logic [AW-1:0]            rd_addr,
  output logic [1:0]               rd_size,
  input  logic                     rd_ack,
  input  logic [31:0]              rd_data,
  output logic                     wr_req,
  output logic [AW-1:0]            wr_addr,
  output logic [1:0]               wr_size,
  output logic [31:0]              wr_data,
  input  logic                     wr_ack,
  output logic [NCH-1:0]           irq
);

  localparam int CHW  = $clog2(NCH);
  localparam int SETW = $clog2(NSETS);

  // live channel contexts
  logic [NCH-1:0][31:0] c_opt, c_src, c_dst, c_cnt, c_idx;
  logic [NCH-1:0][15:0] c_ecnt, c_fcnt;
  logic [NCH-1:0]       armed;
  logic [NCH-1:0][PW-1:0] c_prio;

  eng_st_e        st;
  logic [CHW-1:0] cur;
  logic           arm_v_q;
  logic [CHW-1:0] arm_ch_q;

  logic           gnt_v;
  logic [CHW-1:0] gnt_ch;
  logic           take;

  logic [1:0][SETW-1:0] st_idx;
  pset_t [1:0]          st_set;

  logic [31:0] opt;
  logic [AW-1:0] src_nx, dst_nx;
  logic last_in_frame, last_blk, keep_going, chain;

  for (genvar c = 0; c < NCH; c++) begin : g_prio
    assign c_prio[c] = c_opt[c][OPT_PRIO +: PW];
  end

  // arm request follows a write to the options word of a channel-owned set
  always_ff @(posedge clk) begin
    if (rst) begin
      arm_v_q  <= 1'b0;
      arm_ch_q <= '0;
    end else begin
      arm_v_q  <= cfg_we && (cfg_word == 3'd0) && (int'(cfg_set) < NCH);
      arm_ch_q <= CHW'(cfg_set);
    end
  end

  assign opt           = c_opt[cur];
  assign last_in_frame = (c_ecnt[cur] <= 16'd1);
  assign last_blk      = last_in_frame && (c_fcnt[cur] <= 16'd1);
  assign keep_going    = opt[OPT_FSYNC] && !last_in_frame;
  assign chain         = opt[OPT_LINK] || opt[OPT_RELOAD];

  assign st_idx[0] = SETW'(arm_ch_q);
  assign st_idx[1] = opt[OPT_LINK] ? opt[OPT_LSET +: SETW] : SETW'(cur);

  dma_param_store #(.NSETS(NSETS), .NRD(2)) u_store (
    .clk    (clk),
    .we     (cfg_we),
    .wset   (cfg_set),
    .wword  (cfg_word),
    .wdata  (cfg_wdata),
    .rd_idx (st_idx),
    .rd_set (st_set)
  );

  assign take = (st == ST_IDLE) && gnt_v;

  dma_evt_arbiter #(.NCH(NCH), .PW(PW)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt),
    .armed   (armed),
    .prio    (c_prio),
    .take    (take),
    .take_ch (gnt_ch),
    .gnt_v   (gnt_v),
    .gnt_ch  (gnt_ch)
  );

  dma_addr_step #(.AW(AW)) u_src_step (
    .cur   (c_src[cur][AW-1:0]),
    .mode  (opt[3:2]),
    .esize (opt[1:0]),
    .idx   (c_idx[cur][15:0]),
    .nxt   (src_nx)
  );

  dma_addr_step #(.AW(AW)) u_dst_step (
    .cur   (c_dst[cur][AW-1:0]),
    .mode  (opt[5:4]),
    .esize (opt[1:0]),
    .idx   (c_idx[cur][31:16]),
    .nxt   (dst_nx)
  );

  // context update: engine progress first, an arm load for the same channel wins
  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= '0;
      c_opt  <= '0;
      c_src  <= '0;
      c_dst  <= '0;
      c_cnt  <= '0;
      c_idx  <= '0;
      c_ecnt <= '0;
      c_fcnt <= '0;
    end else begin
      if (st == ST_UPD) begin
        c_src[cur] <= 32'(src_nx);
        c_dst[cur] <= 32'(dst_nx);
        if (last_blk) begin
          if (chain) begin
            c_opt[cur]  <= st_set[1].opt;
            c_src[cur]  <= st_set[1].src;
            c_dst[cur]  <= st_set[1].dst;
            c_cnt[cur]  <= st_set[1].cnt;
            c_idx[cur]  <= st_set[1].idx;
            c_ecnt[cur] <= st_set[1].cnt[15:0];
            c_fcnt[cur] <= st_set[1].cnt[31:16];
          end else begin
            armed[cur] <= 1'b0;
          end
        end else if (last_in_frame) begin
          c_ecnt[cur] <= c_cnt[cur][15:0];
          c_fcnt[cur] <= c_fcnt[cur] - 16'd1;
        end else begin
          c_ecnt[cur] <= c_ecnt[cur] - 16'd1;
        end
      end
      if (arm_v_q) begin
        c_opt[arm_ch_q]  <= st_set[0].opt;
        c_src[arm_ch_q]  <= st_set[0].src;
        c_dst[arm_ch_q]  <= st_set[0].dst;
        c_cnt[arm_ch_q]  <= st_set[0].cnt;
        c_idx[arm_ch_q]  <= st_set[0].idx;
        c_ecnt[arm_ch_q] <= st_set[0].cnt[15:0];
        c_fcnt[arm_ch_q] <= st_set[0].cnt[31:16];
        armed[arm_ch_q]  <= 1'b1;
      end
    end
  end

  // transfer engine with registered request ports
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cur     <= '0;
      rd_req  <= 1'b0;
      rd_addr <= '0;
      rd_size <= '0;
      wr_req  <= 1'b0;
      wr_addr <= '0;
      wr_size <= '0;
      wr_data <= '0;
      irq     <= '0;
    end else begin
      irq <= '0;
      case (st)
        ST_IDLE: begin
          if (gnt_v) begin
            cur     <= gnt_ch;
            rd_req  <= 1'b1;
            rd_addr <= c_src[gnt_ch][AW-1:0];
            rd_size <= c_opt[gnt_ch][1:0];
            st      <= ST_RD;
          end
        end
        ST_RD: begin
          if (rd_ack) begin
            rd_req  <= 1'b0;
            wr_req  <= 1'b1;
            wr_addr <= c_dst[cur][AW-1:0];
            wr_size <= rd_size;
            wr_data <= lane_mask(rd_data, rd_size);
            st      <= ST_WR;
          end
        end
        ST_WR: begin
          if (wr_ack) begin
            wr_req <= 1'b0;
            st     <= ST_UPD;
          end
        end
        ST_UPD: begin
          if (last_blk) irq[cur] <= 1'b1;
          if (keep_going) begin
            rd_req  <= 1'b1;
            rd_addr <= src_nx;
            st      <= ST_RD;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic opt_unused;
  assign opt_unused = ^{opt[15:OPT_PRIO+PW], opt[31:OPT_LSET+SETW]};

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int NCH = 16,
  parameter int AW  = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           rd_req,
  input logic [AW-1:0]  rd_addr,
  input logic [1:0]     rd_size,
  input logic           rd_ack,
  input logic           wr_req,
  input logic [AW-1:0]  wr_addr,
  input logic [1:0]     wr_size,
  input logic [31:0]    wr_data,
  input logic           wr_ack,
  input logic [NCH-1:0] irq
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!rd_req && !wr_req && irq == '0));

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr) && $stable(rd_size)));

  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  assert_rd_then_wr_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_ack) |=> wr_req);

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));

  assert_size_follow_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_ack) |=> (wr_size == $past(rd_size)));

  assert_irq_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq));

  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (|irq) |=> (irq == '0));

endmodule

bind dma_chan_engine dma_chan_engine_chk #(.NCH(NCH), .AW(AW)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .rd_req  (rd_req),
  .rd_addr (rd_addr),
  .rd_size (rd_size),
  .rd_ack  (rd_ack),
  .wr_req  (wr_req),
  .wr_addr (wr_addr),
  .wr_size (wr_size),
  .wr_data (wr_data),
  .wr_ack  (wr_ack),
  .irq     (irq)
);

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb_top;

  localparam int NCH   = 16;
  localparam int NSETS = 32;
  localparam int SETW  = $clog2(NSETS);
  localparam int AW    = 32;
  localparam int NV    = 5;

  // opt, src, dst, counts, indices
  localparam logic [159:0] VEC [NV] = '{
    {32'h0000_0014, 32'h00, 32'h80, 32'h0001_0004, 32'h0},
    {32'h0000_0025, 32'h10, 32'hA0, 32'h0002_0003, 32'h0},
    {32'h0000_0052, 32'h20, 32'hB0, 32'h0003_0002, 32'h0},
    {32'h0000_007C, 32'h30, 32'hCF, 32'h0001_0005, 32'hFFFF_0003},
    {32'h0000_005A, 32'h5C, 32'hD0, 32'h0002_0004, 32'h0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [SETW-1:0] cfg_set = '0;
  logic [2:0] cfg_word = '0;
  logic [31:0] cfg_wdata = '0;
  logic [NCH-1:0] evt = '0;
  logic rd_req, wr_req;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [1:0] rd_size, wr_size;
  logic [31:0] rd_data, wr_data;
  logic ack_ok = 1'b1;
  logic stall_en = 1'b0;
  logic [NCH-1:0] irq;

  logic [7:0] mem [256];
  logic [7:0] mdl [256];
  int wr_n = 0;
  int wr_log [1024];
  int irq_n [NCH];
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  dma_chan_engine #(.NCH(NCH), .NSETS(NSETS), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_set(cfg_set), .cfg_word(cfg_word),
    .cfg_wdata(cfg_wdata), .evt(evt), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_size(rd_size), .rd_ack(ack_ok), .rd_data(rd_data), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data), .wr_ack(ack_ok), .irq(irq)
  );

  always_comb begin
    logic [7:0] a;
    a = rd_addr[7:0];
    case (rd_size)
      2'd0:    rd_data = {24'd0, mem[a]};
      2'd1:    rd_data = {16'd0, mem[8'(a + 1)], mem[a]};
      default: rd_data = {mem[8'(a + 3)], mem[8'(a + 2)], mem[8'(a + 1)], mem[a]};
    endcase
  end

  // memory, write log, interrupt counters and handshake throttle
  always @(negedge clk) begin
    if (wr_req && ack_ok) begin
      for (int b = 0; b < (1 << wr_size); b++) mem[8'(wr_addr[7:0] + b)] = wr_data[8*b +: 8];
      wr_log[wr_n % 1024] = int'(wr_addr);
      wr_n = wr_n + 1;
    end
    for (int c = 0; c < NCH; c++) if (irq[c]) irq_n[c] = irq_n[c] + 1;
    ack_ok = stall_en ? 1'($urandom % 2) : 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input int set, input int word, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_set = SETW'(set); cfg_word = 3'(word); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input int set, input logic [31:0] o, s, d, n, x);
    cfg_wr(set, 1, s); cfg_wr(set, 2, d); cfg_wr(set, 3, n); cfg_wr(set, 4, x);
    cfg_wr(set, 0, o);
    repeat (2) @(negedge clk);
  endtask

  task automatic fire(input logic [NCH-1:0] m, input int settle);
    @(negedge clk); evt = m;
    @(negedge clk); evt = '0;
    repeat (settle) @(negedge clk);
  endtask

  function automatic int step(input int a, input int mode, input int sz, input logic [15:0] ix);
    case (mode)
      1: return a + sz;
      2: return a - sz;
      3: return a + int'($signed(ix));
      default: return a;
    endcase
  endfunction

  task automatic model(input logic [159:0] v);
    int o, sz, s, d;
    o = int'(v[159:128]); s = int'(v[127:96]); d = int'(v[95:64]);
    sz = 1 << (o & 3);
    for (int f = 0; f < int'(v[63:48]); f++)
      for (int e = 0; e < int'(v[47:32]); e++) begin
        for (int b = 0; b < sz; b++) mdl[8'(d + b)] = mdl[8'(s + b)];
        s = step(s, (o >> 2) & 3, sz, v[15:0]);
        d = step(d, (o >> 4) & 3, sz, v[31:16]);
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int w0, i0, nev, bad;
    for (int c = 0; c < NCH; c++) irq_n[c] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!rd_req && !wr_req && irq == '0, "R1 reset outputs", {rd_req, wr_req}, 0);

    // R6: event on a never-armed channel is dropped
    w0 = wr_n;
    fire(16'h0080, 40);
    chk(wr_n == w0, "R6 unarmed event ignored", wr_n - w0, 0);

    // vector walk on channel 0: widths, address modes, sync kinds, disarm
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < 256; i++) begin mem[i] = 8'(i) ^ 8'h5A; mdl[i] = mem[i]; end
      stall_en = v[0];
      prog(0, VEC[v][159:128], VEC[v][127:96], VEC[v][95:64], VEC[v][63:32], VEC[v][31:0]);
      nev = VEC[v][134] ? int'(VEC[v][63:48]) : int'(VEC[v][63:48]) * int'(VEC[v][47:32]);
      w0 = wr_n; i0 = irq_n[0];
      for (int k = 0; k < nev; k++) begin
        fire(16'h0001, 60);
        if (k == 0)
          chk(wr_n - w0 == (VEC[v][134] ? int'(VEC[v][47:32]) : 1),
              "R5 elements per event", wr_n - w0, VEC[v][134] ? VEC[v][47:32] : 1);
      end
      model(VEC[v]);
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== mdl[i]) bad++;
      chk(bad == 0, "R2 R3 R4 moved bytes match", bad, 0);
      chk(irq_n[0] - i0 == 1, "R9 one completion pulse", irq_n[0] - i0, 1);
      w0 = wr_n;
      fire(16'h0001, 40);
      chk(wr_n == w0, "R12 disarmed after block", wr_n - w0, 0);
    end
    stall_en = 1'b0;

    // R7: priority then lowest index
    prog(3, 32'h0000_0414, 32'h03, 32'h83, 32'h0001_0001, 32'h0);
    prog(5, 32'h0000_0A14, 32'h05, 32'h85, 32'h0001_0001, 32'h0);
    prog(1, 32'h0000_0A14, 32'h01, 32'h81, 32'h0001_0001, 32'h0);
    w0 = wr_n;
    fire(16'h002A, 60);
    chk(wr_log[w0] == 32'h81, "R7 tie goes to lowest index", wr_log[w0], 32'h81);
    chk(wr_log[w0 + 1] == 32'h85, "R7 higher priority next", wr_log[w0 + 1], 32'h85);
    chk(wr_log[w0 + 2] == 32'h83, "R7 lowest priority last", wr_log[w0 + 2], 32'h83);

    // R6: event coinciding with consumption is kept, only one pending
    prog(6, 32'h0000_0014, 32'h00, 32'h70, 32'h0001_0004, 32'h0);
    w0 = wr_n;
    @(negedge clk); evt = 16'h0040;
    repeat (3) @(negedge clk);
    evt = '0;
    repeat (40) @(negedge clk);
    chk(wr_n - w0 == 2, "R6 same-edge event kept", wr_n - w0, 2);

    // R10: reload restarts from original addresses
    prog(2, 32'h0000_00D4, 32'h00, 32'h40, 32'h0001_0002, 32'h0);
    i0 = irq_n[2];
    fire(16'h0004, 40);
    w0 = wr_n;
    fire(16'h0004, 40);
    chk(wr_n - w0 == 2 && wr_log[w0] == 32'h40, "R10 reload restart", wr_log[w0], 32'h40);
    chk(irq_n[2] - i0 == 2, "R9 R10 pulse per block", irq_n[2] - i0, 2);

    // R11: link overrides reload; linked set then disarms (R12)
    prog(20, 32'h0000_0054, 32'h10, 32'h60, 32'h0001_0001, 32'h0);
    prog(4, 32'h0014_01D4, 32'h10, 32'h50, 32'h0001_0001, 32'h0);
    w0 = wr_n;
    fire(16'h0010, 40);
    chk(wr_log[w0] == 32'h50, "R11 first block own set", wr_log[w0], 32'h50);
    fire(16'h0010, 40);
    chk(wr_log[w0 + 1] == 32'h60, "R11 linked set loaded", wr_log[w0 + 1], 32'h60);
    fire(16'h0010, 40);
    chk(wr_n - w0 == 2, "R12 linked set ends idle", wr_n - w0, 2);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule